// File: doc/BRIEF.md
# In-band interrupt retry controller

This block schedules in-band interrupt (IBI) requests for an I3C target. Software-side logic pushes IBI payloads into a small byte queue. Each payload is one or more bytes, and the last byte is flagged. The mandatory data byte always comes first, so a payload is never empty. When servicing is enabled, the queue holds a payload, and the target owns a usable address, the controller raises an attempt request toward the serial engine. It also presents the address byte and the head payload byte.

The serial engine handles shifting and arbitration and is outside this block. It reports back through a small handshake. One pulse consumes a payload byte. A second pulse, with a 2-bit code, reports how the attempt ended. The controller applies a programmable retry limit to NACKs seen before any data and to lost arbitration. It drops the unsent remainder of a payload when the NACK comes after data has started. It records the most recent outcome in a 3-bit status field and raises a one-cycle done pulse with it. Two reset strobes are provided: one empties the queue and abandons any attempt, and the other clears only the retry bookkeeping.

Top module: `ibi_retry_ctrl`

## Requirements
- R1: The servicing enable resets to 1. While it is 0, no attempt is started. A write strobe loads a new enable value, which takes effect from the next cycle.
- R2: An attempt starts only when the dynamic address or the static address is valid. The address byte is {dynamic address, 1} when the dynamic address is valid, and {static address, 1} otherwise.
- R3: An attempt starts only when the queue holds a byte. While the attempt request is high, the head byte and its last flag are presented. Each byte-take pulse removes one byte. A push is accepted whenever the ready output is high, and ready is low only when the queue is full.
- R4: Outcome code 00 (acknowledged) sets status 000, raises done and clears the retry counter. Any payload bytes that were not taken are removed.
- R5: Outcome code 01 (NACK before data) sets status 001, and code 11 (arbitration lost) sets status 100, provided the retry counter is below the retry limit. The counter then increases by one, the payload stays queued and a new attempt follows.
- R6: A retry limit of 7 never runs out. Every NACK before data gives status 001 and leads to another attempt.
- R7: If a NACK before data or a lost arbitration arrives when the counter has reached a limit below 7, status 011 is set. The payload stays queued, and no further attempt starts until the retry-counter reset.
- R8: Outcome code 10 (NACK after partial data) sets status 010 and clears the retry counter. The rest of that payload, up to and including its last-flagged byte, is discarded. The next attempt presents the following payload.
- R9: Done is high for exactly one cycle, in the same cycle that status takes its new value. Status holds the latest outcome only and resets to 000. An outcome is taken only while the attempt request is high.
- R10: A queue reset empties the queue, drops the attempt request in the next cycle and returns the controller to idle. A push in that same cycle is discarded. Status and the retry counter are not touched.
- R11: A retry-counter reset clears the counter and the exhausted condition. Queued bytes are kept, and the held payload is attempted again.
- R12: When an outcome and a retry-counter reset arrive in the same cycle, status reflects the outcome judged against the old counter. The counter and the exhausted condition still end up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_i | input | 1 | Strobe that loads the servicing enable |
| en_val_i | input | 1 | New enable value |
| retry_num_i | input | RETRY_W | Retry limit; all ones means unlimited |
| dyn_addr_i | input | ADDR_W | Dynamic address |
| dyn_valid_i | input | 1 | Dynamic address valid |
| stat_addr_i | input | ADDR_W | Static address |
| stat_valid_i | input | 1 | Static address valid |
| wr_valid_i | input | 1 | Push a payload byte |
| wr_data_i | input | DATA_W | Payload byte |
| wr_last_i | input | 1 | Byte ends its payload |
| wr_ready_o | output | 1 | Queue can accept a byte |
| queue_rst_i | input | 1 | Empty queue, abandon attempt |
| ctr_rst_i | input | 1 | Clear retry counter and exhausted state |
| req_o | output | 1 | Attempt request to the serial engine |
| addr_o | output | ADDR_W+1 | Address byte with read bit set |
| byte_o | output | DATA_W | Head payload byte |
| byte_last_o | output | 1 | Head byte ends the payload |
| byte_take_i | input | 1 | Engine consumed the head byte |
| out_valid_i | input | 1 | Engine reports the attempt outcome |
| out_code_i | input | 2 | 00 ack, 01 NACK before data, 10 NACK after data, 11 arbitration lost |
| status_o | output | 3 | Last outcome code |
| done_o | output | 1 | One-cycle pulse on status update |

## Verification
The collision of interest is an attempt outcome landing in the same cycle as the retry-counter reset. Here the status decision and the counter clearing compete for the same state. The bench provokes it by setting a limit of 1 and letting one NACK use up the single retry. It then reports a second NACK together with the counter reset. The bench judges it by expecting status 011 from the old counter, followed by a fresh attempt on the kept payload, which shows that the exhausted condition was cleared. A behavioural model with a byte queue follows every cycle, so a queue reset that meets a push, a byte take or an outcome is also compared as it happens.

// File: rtl/ibi_pkg.sv
package ibi_pkg;

  typedef enum logic [2:0] {
    ST_OK        = 3'b000,
    ST_NACK      = 3'b001,
    ST_PARTIAL   = 3'b010,
    ST_EXHAUSTED = 3'b011,
    ST_ARB       = 3'b100
  } ibi_status_e;

  typedef enum logic [1:0] {
    OUT_ACK       = 2'b00,
    OUT_NACK_ADDR = 2'b01,
    OUT_NACK_DATA = 2'b10,
    OUT_ARB_LOST  = 2'b11
  } outcome_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'b00,
    S_ACTIVE = 2'b01,
    S_DROP   = 2'b10
  } seq_state_e;

endpackage

// File: rtl/ibi_fifo.sv
module ibi_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count_q;
  logic             do_push, do_pop;

  assign full    = (count_q == (AW+1)'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + (AW+1)'(1);
        2'b01:   count_q <= count_q - (AW+1)'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count_q <= (AW+1)'(DEPTH));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/ibi_addr_sel.sv
module ibi_addr_sel #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic              dyn_valid,
  input  logic [ADDR_W-1:0] stat_addr,
  input  logic              stat_valid,
  output logic [ADDR_W:0]   addr_byte,
  output logic              addr_ok
);
  logic [ADDR_W-1:0] chosen;

  assign chosen    = dyn_valid ? dyn_addr : stat_addr;
  assign addr_byte = {chosen, 1'b1};
  assign addr_ok   = dyn_valid || stat_valid;

endmodule

// File: rtl/ibi_seq.sv
module ibi_seq
  import ibi_pkg::*;
#(
  parameter int RETRY_W = 3,
  parameter int ADDR_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr_i,
  input  logic               en_val_i,
  input  logic [RETRY_W-1:0] retry_num_i,
  input  logic               addr_ok_i,
  input  logic [ADDR_W:0]    addr_byte_i,
  input  logic               q_empty_i,
  input  logic               q_head_last_i,
  input  logic               byte_take_i,
  input  logic               out_valid_i,
  input  outcome_e           out_code_i,
  input  logic               queue_rst_i,
  input  logic               ctr_rst_i,
  output logic               pop_o,
  output logic               req_o,
  output logic [ADDR_W:0]    addr_o,
  output ibi_status_e        status_o,
  output logic               done_o
);
  localparam logic [RETRY_W-1:0] FOREVER = '1;

  seq_state_e         st_q;
  logic               en_q, exh_q, tk_q;
  logic [RETRY_W-1:0] cnt_q;
  logic               take, take_last, outcome, can_retry, start, all_taken;

  assign take      = (st_q == S_ACTIVE) && byte_take_i && !q_empty_i;
  assign take_last = take && q_head_last_i;
  assign all_taken = tk_q || take_last;
  assign outcome   = (st_q == S_ACTIVE) && out_valid_i;
  assign can_retry = (retry_num_i == FOREVER) || (cnt_q < retry_num_i);
  assign start     = (st_q == S_IDLE) && !q_empty_i && en_q && addr_ok_i && !exh_q;
  assign pop_o     = !queue_rst_i && (take || ((st_q == S_DROP) && !q_empty_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      en_q     <= 1'b1;
      exh_q    <= 1'b0;
      tk_q     <= 1'b0;
      cnt_q    <= '0;
      req_o    <= 1'b0;
      addr_o   <= '0;
      status_o <= ST_OK;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (en_wr_i) en_q <= en_val_i;
      if (queue_rst_i) begin
        st_q  <= S_IDLE;
        req_o <= 1'b0;
        tk_q  <= 1'b0;
      end else begin
        case (st_q)
          S_IDLE: begin
            if (start) begin
              st_q   <= S_ACTIVE;
              req_o  <= 1'b1;
              addr_o <= addr_byte_i;
              tk_q   <= 1'b0;
            end
          end
          S_ACTIVE: begin
            if (outcome) begin
              req_o  <= 1'b0;
              done_o <= 1'b1;
              tk_q   <= 1'b0;
              case (out_code_i)
                OUT_ACK: begin
                  status_o <= ST_OK;
                  cnt_q    <= '0;
                  st_q     <= all_taken ? S_IDLE : S_DROP;
                end
                OUT_NACK_DATA: begin
                  status_o <= ST_PARTIAL;
                  cnt_q    <= '0;
                  st_q     <= all_taken ? S_IDLE : S_DROP;
                end
                default: begin
                  st_q <= S_IDLE;
                  if (can_retry) begin
                    status_o <= (out_code_i == OUT_NACK_ADDR) ? ST_NACK : ST_ARB;
                    if (cnt_q != FOREVER) cnt_q <= cnt_q + RETRY_W'(1);
                  end else begin
                    status_o <= ST_EXHAUSTED;
                    exh_q    <= 1'b1;
                  end
                end
              endcase
            end else if (take_last) begin
              tk_q <= 1'b1;
            end
          end
          S_DROP: begin
            if (q_empty_i || q_head_last_i) st_q <= S_IDLE;
          end
          default: st_q <= S_IDLE;
        endcase
      end
      if (ctr_rst_i) begin
        cnt_q <= '0;
        exh_q <= 1'b0;
      end
    end
  end

  assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(addr_ok_i));

  assert_start_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(en_q));

  assert_exhausted_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> !$past(exh_q));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_after_req_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(req_o));

  assert_status_legal_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (status_o inside {ST_OK, ST_NACK, ST_PARTIAL, ST_EXHAUSTED, ST_ARB}));

endmodule

// File: rtl/ibi_retry_ctrl.sv
module ibi_retry_ctrl
  import ibi_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr_i,
  input  logic               en_val_i,
  input  logic [RETRY_W-1:0] retry_num_i,
  input  logic [ADDR_W-1:0]  dyn_addr_i,
  input  logic               dyn_valid_i,
  input  logic [ADDR_W-1:0]  stat_addr_i,
  input  logic               stat_valid_i,
  input  logic               wr_valid_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               wr_last_i,
  output logic               wr_ready_o,
  input  logic               queue_rst_i,
  input  logic               ctr_rst_i,
  output logic               req_o,
  output logic [ADDR_W:0]    addr_o,
  output logic [DATA_W-1:0]  byte_o,
  output logic               byte_last_o,
  input  logic               byte_take_i,
  input  logic               out_valid_i,
  input  logic [1:0]         out_code_i,
  output logic [2:0]         status_o,
  output logic               done_o
);
  localparam int ENTRY_W = DATA_W + 1;

  logic [ENTRY_W-1:0] head;
  logic               q_full, q_empty, pop;
  logic [ADDR_W:0]    addr_byte;
  logic               addr_ok;
  ibi_status_e        status_e;
  outcome_e           code_e;

  assign code_e      = outcome_e'(out_code_i);
  assign status_o    = status_e;
  assign wr_ready_o  = !q_full;
  assign byte_o      = head[DATA_W-1:0];
  assign byte_last_o = head[DATA_W];

  ibi_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (queue_rst_i),
    .push  (wr_valid_i),
    .din   ({wr_last_i, wr_data_i}),
    .pop   (pop),
    .dout  (head),
    .full  (q_full),
    .empty (q_empty)
  );

  ibi_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
    .dyn_addr   (dyn_addr_i),
    .dyn_valid  (dyn_valid_i),
    .stat_addr  (stat_addr_i),
    .stat_valid (stat_valid_i),
    .addr_byte  (addr_byte),
    .addr_ok    (addr_ok)
  );

  ibi_seq #(.RETRY_W(RETRY_W), .ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .en_wr_i       (en_wr_i),
    .en_val_i      (en_val_i),
    .retry_num_i   (retry_num_i),
    .addr_ok_i     (addr_ok),
    .addr_byte_i   (addr_byte),
    .q_empty_i     (q_empty),
    .q_head_last_i (head[DATA_W]),
    .byte_take_i   (byte_take_i),
    .out_valid_i   (out_valid_i),
    .out_code_i    (code_e),
    .queue_rst_i   (queue_rst_i),
    .ctr_rst_i     (ctr_rst_i),
    .pop_o         (pop),
    .req_o         (req_o),
    .addr_o        (addr_o),
    .status_o      (status_e),
    .done_o        (done_o)
  );

  assert_queue_reset_R10: assert property (@(posedge clk) disable iff (rst)
    queue_rst_i |=> (!req_o && q_empty));

endmodule

// File: tb/tb_ibi_retry_ctrl.sv
module tb_ibi_retry_ctrl;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       en_wr = 0, en_val = 0;
  logic [2:0] retry_num = 3'd0;
  logic [6:0] dyn_addr = 0, stat_addr = 0;
  logic       dyn_valid = 0, stat_valid = 0;
  logic       wr_valid = 0, wr_last = 0;
  logic [7:0] wr_data = 0;
  logic       queue_rst = 0, ctr_rst = 0;
  logic       byte_take = 0, out_valid = 0;
  logic [1:0] out_code = 0;
  logic       wr_ready, req_o, byte_last, done_o;
  logic [7:0] addr_o, byte_o;
  logic [2:0] status_o;

  ibi_retry_ctrl dut (
    .clk(clk), .rst(rst), .en_wr_i(en_wr), .en_val_i(en_val), .retry_num_i(retry_num),
    .dyn_addr_i(dyn_addr), .dyn_valid_i(dyn_valid), .stat_addr_i(stat_addr),
    .stat_valid_i(stat_valid), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_last_i(wr_last), .wr_ready_o(wr_ready), .queue_rst_i(queue_rst),
    .ctr_rst_i(ctr_rst), .req_o(req_o), .addr_o(addr_o), .byte_o(byte_o),
    .byte_last_o(byte_last), .byte_take_i(byte_take), .out_valid_i(out_valid),
    .out_code_i(out_code), .status_o(status_o), .done_o(done_o)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: byte queue plus a handful of flags
  logic [8:0] mq[$];
  int         m_st, m_cnt, sz0;
  bit         m_en, m_exh, m_tk, m_req, m_done, tl, hl;
  logic [7:0] m_addr;
  logic [2:0] m_stat;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mq.delete(); m_st = 0; m_cnt = 0; m_en = 1; m_exh = 0; m_tk = 0;
      m_req = 0; m_done = 0; m_addr = 0; m_stat = 0;
    end else begin
      sz0 = mq.size();
      m_done = 0;
      if (queue_rst) begin
        mq.delete(); m_st = 0; m_req = 0; m_tk = 0;
      end else begin
        if (m_st == 1) begin
          tl = 0;
          if (byte_take && mq.size() > 0) begin tl = mq[0][8]; void'(mq.pop_front()); end
          if (out_valid) begin
            m_done = 1; m_req = 0;
            if (out_code == 2'b00 || out_code == 2'b10) begin
              m_stat = (out_code == 2'b00) ? 3'b000 : 3'b010;
              m_cnt = 0;
              m_st = (m_tk || tl) ? 0 : 2;
            end else begin
              m_st = 0;
              if (retry_num == 3'd7 || m_cnt < retry_num) begin
                m_stat = (out_code == 2'b01) ? 3'b001 : 3'b100;
                if (m_cnt != 7) m_cnt++;
              end else begin
                m_stat = 3'b011; m_exh = 1;
              end
            end
            m_tk = 0;
          end else if (tl) m_tk = 1;
        end else if (m_st == 2) begin
          if (mq.size() == 0) m_st = 0;
          else begin hl = mq[0][8]; void'(mq.pop_front()); if (hl) m_st = 0; end
        end else if (mq.size() > 0 && m_en && (dyn_valid || stat_valid) && !m_exh) begin
          m_st = 1; m_req = 1; m_tk = 0;
          m_addr = {(dyn_valid ? dyn_addr : stat_addr), 1'b1};
        end
        if (wr_valid && sz0 < DEPTH) mq.push_back({wr_last, wr_data});
      end
      if (ctr_rst) begin m_cnt = 0; m_exh = 0; end
      if (en_wr) m_en = en_val;
      #5;
      chk("R3 req_o", req_o, m_req);
      chk("R9 done_o", done_o, m_done);
      chk("R9 status_o", status_o, m_stat);
      chk("R3 wr_ready_o", wr_ready, mq.size() < DEPTH);
      if (m_req) chk("R2 addr_o", addr_o, m_addr);
      if (m_req && mq.size() > 0) begin
        chk("R3 byte_o", byte_o, mq[0][7:0]);
        chk("R3 byte_last_o", byte_last, mq[0][8]);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_desc(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_data = base + 8'(i); wr_last = (i == n - 1);
    end
    @(negedge clk);
    wr_valid = 0; wr_last = 0;
  endtask

  task automatic pulse_ctr_rst();
    @(negedge clk); ctr_rst = 1;
    @(negedge clk); ctr_rst = 0;
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk); en_wr = 1; en_val = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic wait_req(input string tag);
    int w = 0;
    @(negedge clk);
    while (!req_o && w < 200) begin @(negedge clk); w++; end
    chk({tag, " attempt started"}, req_o, 1);
  endtask

  task automatic attempt(input logic [1:0] code, input int ntake, input bit crst,
                         input logic [2:0] exp_stat, input string tag);
    wait_req(tag);
    for (int i = 0; i < ntake; i++) begin
      byte_take = 1; @(negedge clk); byte_take = 0;
    end
    out_valid = 1; out_code = code; ctr_rst = crst;
    @(negedge clk);
    out_valid = 0; ctr_rst = 0;
    chk({tag, " done pulse"}, done_o, 1);
    chk({tag, " status"}, status_o, exp_stat);
    @(negedge clk);
    chk("R9 done falls", done_o, 0);
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R9 reset status", status_o, 0);
    chk("R9 reset done", done_o, 0);
    chk("R3 reset req", req_o, 0);
    chk("R3 reset ready", wr_ready, 1);

    // R2: no valid address, no attempt; then static address used
    push_desc(2, 8'h10);
    idle(5);
    chk("R2 no address no attempt", req_o, 0);
    stat_addr = 7'h2A; stat_valid = 1;
    wait_req("R2");
    chk("R2 static address byte", addr_o, 8'h55);
    chk("R1 enabled from reset", req_o, 1);
    attempt(2'b00, 2, 0, 3'b000, "R4 ack");

    // R2: dynamic address wins
    dyn_addr = 7'h11; dyn_valid = 1;
    push_desc(1, 8'h20);
    wait_req("R2");
    chk("R2 dynamic address byte", addr_o, 8'h23);
    attempt(2'b00, 1, 0, 3'b000, "R4 ack dyn");

    // R1: disabled
    set_enable(0);
    push_desc(1, 8'h30);
    idle(6);
    chk("R1 disabled no attempt", req_o, 0);
    set_enable(1);
    attempt(2'b00, 1, 0, 3'b000, "R1 re-enabled");

    // R5 / R7 / R11
    retry_num = 3'd2;
    push_desc(2, 8'h40);
    attempt(2'b01, 0, 0, 3'b001, "R5 nack");
    attempt(2'b11, 0, 0, 3'b100, "R5 arb lost");
    attempt(2'b01, 0, 0, 3'b011, "R7 exhausted");
    idle(8);
    chk("R7 no attempt after exhaustion", req_o, 0);
    chk("R7 payload kept", wr_ready, 1);
    pulse_ctr_rst();
    wait_req("R11");
    chk("R11 kept payload head", byte_o, 8'h40);
    attempt(2'b00, 2, 0, 3'b000, "R11 retried ack");

    // R6: unlimited
    retry_num = 3'd7;
    push_desc(1, 8'h50);
    for (int i = 0; i < 9; i++) attempt(2'b01, 0, 0, 3'b001, "R6 unlimited");
    attempt(2'b00, 1, 0, 3'b000, "R6 final ack");

    // R8: partial NACK drops rest
    retry_num = 3'd2;
    push_desc(3, 8'h60);
    push_desc(1, 8'h70);
    attempt(2'b10, 1, 0, 3'b010, "R8 partial");
    wait_req("R8");
    chk("R8 next payload presented", byte_o, 8'h70);
    attempt(2'b00, 1, 0, 3'b000, "R8 next ack");

    // R10: queue reset mid-attempt
    push_desc(2, 8'h80);
    wait_req("R10");
    byte_take = 1; @(negedge clk); byte_take = 0;
    queue_rst = 1; wr_valid = 1; wr_data = 8'hEE; wr_last = 1;
    @(negedge clk);
    queue_rst = 0; wr_valid = 0; wr_last = 0;
    chk("R10 req dropped", req_o, 0);
    chk("R10 status untouched", status_o, 3'b000);
    idle(5);
    chk("R10 queue empty, no attempt", req_o, 0);

    // R7 with limit 0
    retry_num = 3'd0;
    push_desc(1, 8'hA0);
    attempt(2'b01, 0, 0, 3'b011, "R7 zero limit");
    pulse_ctr_rst();
    attempt(2'b00, 1, 0, 3'b000, "R11 after zero limit");

    // R12: outcome and counter reset together
    retry_num = 3'd1;
    push_desc(1, 8'h90);
    attempt(2'b01, 0, 0, 3'b001, "R12 first nack");
    attempt(2'b01, 0, 1, 3'b011, "R12 collide");
    attempt(2'b00, 1, 0, 3'b000, "R12 resumed");

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule